// File: doc/BRIEF.md
# Filtered PLL Lock Indicator

This block watches the reference clock and the divided feedback clock of a phase-locked loop and produces a single lock flag. It does not compare every cycle. It counts leading reference edges and takes one phase-error measurement per decimation interval. The measurement is the distance, in periods of a fast measurement clock, between a leading reference edge and the nearest leading feedback edge. The feedback edge may come before or after the reference edge.

Each measurement is classed as inside or outside a window. A run of in-window samples raises the flag. One out-of-window sample drops it at once. Two conditions count as out-of-window samples: a feedback edge that never arrives, and a reference clock that stops. A select input either shows the filtered status or holds the output low. The reference and feedback inputs are assumed to be already synchronous to the measurement clock. The reference period must be longer than the window.

Top module: `pll_lock_filter`

## Requirements
- R1: One measurement is taken on every DECIM-th leading reference edge (default 64). The first measurement is on the DECIM-th edge after reset. The edge counter keeps running during a measurement.
- R2: A sample is in window only when the distance between the two leading edges is less than WIN_CYC measurement-clock periods (default 2, i.e. 10 ns at 5 ns). A feedback edge that leads counts backward from the reference edge. One that lags counts forward. Edges in the same cycle have distance 0.
- R3: lock_o goes high after RUN_LEN (default 4) consecutive in-window samples. The run counter saturates at RUN_LEN. The flag updates one clock after the sample decision, and the decision is registered one clock after the deciding edge is sampled.
- R4: A single out-of-window sample clears both the lock flag and the run counter.
- R5: Two cases count as out-of-window samples. The first is no feedback edge within the window after a measured reference edge. The second is REF_TMO_CYC clocks with no leading reference edge, which repeats every REF_TMO_CYC clocks while the reference stays silent.
- R6: While ld_sel_i is 0, lock_o is held at 0. The filtered status is still kept, and it appears as soon as ld_sel_i returns to 1.
- R7: Reset (active low, asynchronous) clears the flag, the run counter, the decimation count and any measurement in progress. While the loop is not locked, lock_o is 0.
- R8: The leading edge is the rising edge when LEAD_RISE is 1 and the falling edge when it is 0. Inputs are sampled on rising measurement-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast measurement clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock, synchronous to clk_i |
| fb_i | input | 1 | Divided feedback clock, synchronous to clk_i |
| ld_sel_i | input | 1 | 1 shows lock status, 0 forces output low |
| lock_o | output | 1 | Filtered lock indicator |

## Verification
The loop is first driven with aligned edges, then with feedback lagging and leading by one measurement period, which must stay in window. It is then driven with lags and leads of two periods, which must not, so the window boundary is tested from both sides. Realignment after each failure shows that lock needs a full new run and is not restored by a single good sample. Removing the feedback clock and then the reference clock separates a missing partner edge from a stopped reference. Toggling the select input while locked shows that the hidden status survives masking.

// File: rtl/pll_lock_pkg.sv
`timescale 1ns/1ps
package pll_lock_pkg;

   typedef enum logic {
      MS_IDLE = 1'b0,
      MS_WAIT = 1'b1
   } meas_state_e;

   typedef struct packed {
      logic vld;
      logic good;
   } lock_sample_t;

endpackage

// File: rtl/pll_lock_edge.sv
`timescale 1ns/1ps
module pll_lock_edge #(
   parameter bit LEAD_RISE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic edge_o
);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= LEAD_RISE ? 1'b0 : 1'b1;
      else         prev_q <= sig_i;
   end

   // The leading edge polarity is chosen at elaboration (R8).
   generate
      if (LEAD_RISE) begin : g_rise
         assign edge_o = sig_i & ~prev_q;
      end else begin : g_fall
         assign edge_o = ~sig_i & prev_q;
      end
   endgenerate

endmodule

// File: rtl/pll_lock_decim.sv
`timescale 1ns/1ps
module pll_lock_decim #(
   parameter int unsigned DECIM = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_edge_i,
   output logic fire_o
);

   localparam int unsigned CW = (DECIM > 1) ? $clog2(DECIM) : 1;
   localparam bit          POW2 = ((DECIM & (DECIM - 1)) == 0);
   localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

   logic [CW-1:0] cnt_q;

   assign fire_o = ref_edge_i && (cnt_q == LAST);

   // A power-of-two interval wraps for free. Other intervals compare and clear.
   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)         cnt_q <= '0;
            else if (ref_edge_i) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)         cnt_q <= '0;
            else if (ref_edge_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   // R1: after a measurement fires, counting restarts at zero
   p_fire_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> (cnt_q == '0));

endmodule

// File: rtl/pll_lock_meas.sv
`timescale 1ns/1ps
module pll_lock_meas
   import pll_lock_pkg::*;
#(
   parameter int unsigned WIN_CYC     = 2,
   parameter int unsigned REF_TMO_CYC = 256
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         ref_edge_i,
   input  logic         fb_edge_i,
   input  logic         fire_i,
   output lock_sample_t smp_o
);

   localparam int unsigned SW = $clog2(WIN_CYC + 1);
   localparam int unsigned GW = $clog2(REF_TMO_CYC);
   localparam logic [SW-1:0] WIN_V = SW'(WIN_CYC);
   localparam logic [GW-1:0] GAP_LAST = GW'(REF_TMO_CYC - 1);

   meas_state_e  st_q, st_d;
   logic [SW-1:0] since_fb_q;   // distance to the last feedback edge, saturating
   logic [SW-1:0] k_q, k_d;     // clocks elapsed since the measured reference edge
   logic [GW-1:0] gap_q;        // clocks with no reference edge
   logic          done, done_good, tmo;
   lock_sample_t  smp_q;

   // Tracks how long ago a feedback edge was seen, for the leading case.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               since_fb_q <= WIN_V;
      else if (fb_edge_i)        since_fb_q <= SW'(1);
      else if (since_fb_q < WIN_V) since_fb_q <= since_fb_q + 1'b1;
   end

   // Reference-loss timer.
   assign tmo = !ref_edge_i && (gap_q == GAP_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         gap_q <= '0;
      else if (ref_edge_i) gap_q <= '0;
      else if (tmo)        gap_q <= '0;
      else                 gap_q <= gap_q + 1'b1;
   end

   // Measurement state machine.
   always_comb begin
      st_d      = st_q;
      k_d       = k_q;
      done      = 1'b0;
      done_good = 1'b0;
      unique case (st_q)
         MS_IDLE: begin
            if (fire_i) begin
               if (fb_edge_i || (since_fb_q < WIN_V)) begin
                  done      = 1'b1;
                  done_good = 1'b1;
               end else begin
                  st_d = MS_WAIT;
                  k_d  = SW'(1);
               end
            end
         end
         MS_WAIT: begin
            if (k_q >= WIN_V) begin
               done = 1'b1;
               st_d = MS_IDLE;
            end else if (fb_edge_i) begin
               done      = 1'b1;
               done_good = 1'b1;
               st_d      = MS_IDLE;
            end else begin
               k_d = k_q + 1'b1;
            end
         end
         default: st_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= MS_IDLE;
         k_q   <= '0;
         smp_q <= '0;
      end else begin
         st_q       <= st_d;
         k_q        <= k_d;
         smp_q.vld  <= done | tmo;
         smp_q.good <= done & done_good & ~tmo;
      end
   end

   assign smp_o = smp_q;

   // R2: a lagging search never runs past the window
   p_wait_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == MS_WAIT) |-> (k_q <= WIN_V));

   // R5: a silent reference yields a failed sample
   p_tmo_bad_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ref_edge_i && gap_q == GAP_LAST) |=> (smp_o.vld && !smp_o.good));

endmodule

// File: rtl/pll_lock_flt.sv
`timescale 1ns/1ps
module pll_lock_flt
   import pll_lock_pkg::*;
#(
   parameter int unsigned RUN_LEN = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  lock_sample_t smp_i,
   output logic         locked_o
);

   localparam int unsigned RW = $clog2(RUN_LEN + 1);
   localparam logic [RW-1:0] RUN_V  = RW'(RUN_LEN);
   localparam logic [RW-1:0] RUN_M1 = RW'(RUN_LEN - 1);

   logic [RW-1:0] run_q;
   logic          lk_q;
   logic          s_vld, s_good;

   assign s_vld  = smp_i.vld;
   assign s_good = smp_i.good;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
         lk_q  <= 1'b0;
      end else if (s_vld) begin
         if (s_good) begin
            if (run_q != RUN_V) run_q <= run_q + 1'b1;
            if (run_q >= RUN_M1) lk_q <= 1'b1;
         end else begin
            run_q <= '0;
            lk_q  <= 1'b0;
         end
      end
   end

   assign locked_o = lk_q;

   // R3: the run counter never exceeds its saturation value
   p_run_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RUN_V);

   // R3: lock is gained only on an in-window sample completing a run
   p_lock_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lk_q) |-> ($past(s_vld) && $past(s_good) && $past(run_q) >= RUN_M1));

   // R4: one failed sample drops lock on the next clock
   p_bad_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_vld && !s_good) |=> (!lk_q && run_q == '0));

endmodule

// File: rtl/pll_lock_filter.sv
`timescale 1ns/1ps
module pll_lock_filter
   import pll_lock_pkg::*;
#(
   parameter int unsigned DECIM       = 64,
   parameter int unsigned WIN_CYC     = 2,
   parameter int unsigned RUN_LEN     = 4,
   parameter int unsigned REF_TMO_CYC = 256,
   parameter bit          LEAD_RISE   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_i,
   input  logic fb_i,
   input  logic ld_sel_i,
   output logic lock_o
);

   generate
      if (DECIM < 2) begin : g_bad_decim
         $error("pll_lock_filter: DECIM must be at least 2");
      end
      if (WIN_CYC < 1) begin : g_bad_win
         $error("pll_lock_filter: WIN_CYC must be at least 1");
      end
      if (RUN_LEN < 1) begin : g_bad_run
         $error("pll_lock_filter: RUN_LEN must be at least 1");
      end
      if (REF_TMO_CYC <= 2 * WIN_CYC) begin : g_bad_tmo
         $error("pll_lock_filter: REF_TMO_CYC must exceed twice WIN_CYC");
      end
   endgenerate

   logic         ref_edge, fb_edge, fire, locked;
   lock_sample_t smp;

   pll_lock_edge #(.LEAD_RISE(LEAD_RISE)) u_ref_edge (
      .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(ref_i), .edge_o(ref_edge));

   pll_lock_edge #(.LEAD_RISE(LEAD_RISE)) u_fb_edge (
      .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(fb_i), .edge_o(fb_edge));

   pll_lock_decim #(.DECIM(DECIM)) u_decim (
      .clk_i (clk_i), .rst_ni(rst_ni), .ref_edge_i(ref_edge), .fire_o(fire));

   pll_lock_meas #(.WIN_CYC(WIN_CYC), .REF_TMO_CYC(REF_TMO_CYC)) u_meas (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_edge_i(ref_edge),
      .fb_edge_i (fb_edge),
      .fire_i    (fire),
      .smp_o     (smp));

   pll_lock_flt #(.RUN_LEN(RUN_LEN)) u_flt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .smp_i   (smp),
      .locked_o(locked));

   assign lock_o = ld_sel_i & locked;

   // R6: once locked, a masked output reappears when the select returns
   p_unmask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked && !ld_sel_i && !smp.vld) |=> (locked || smp.vld));

endmodule

// File: tb/sim_pll_lock_filter.sv
`timescale 1ns/1ps
module sim_pll_lock_filter;

   localparam int DECIM = 64;
   localparam int WIN   = 2;
   localparam int RUN   = 4;
   localparam int TMO   = 256;
   localparam int PER   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_i = 1'b0, fb_i = 1'b0, sel = 1'b0;
   logic lock_o;

   int checks = 0, errors = 0;
   string cur_req = "R7";

   // stimulus controls
   bit ref_en = 0, fb_en = 0;
   int off = 0;
   int ph = 0;

   always #2.5 clk = ~clk;

   pll_lock_filter #(.DECIM(DECIM), .WIN_CYC(WIN), .RUN_LEN(RUN),
                     .REF_TMO_CYC(TMO), .LEAD_RISE(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_i), .fb_i(fb_i),
      .ld_sel_i(sel), .lock_o(lock_o));

   // clock waveform generator, drives one time unit after the edge
   always @(posedge clk) begin
      #1;
      ph++;
      ref_i <= ref_en && ((ph % PER) < PER / 2);
      fb_i  <= fb_en && (((ph - off + 1000 * PER) % PER) < PER / 2);
   end

   // behavioural reference model
   int  cyc = 0, nref = 0, last_fb = -1000, wst = 0, gap = 0, run = 0;
   bit  rp = 0, fp = 0, waiting = 0, lk = 0, pv = 0, pg = 0;

   always @(posedge clk) begin
      bit re, fe, dv, dg;
      if (!rst_n) begin
         nref = 0; last_fb = -1000; waiting = 0; gap = 0; run = 0;
         lk = 0; pv = 0; pg = 0; rp = 0; fp = 0;
      end else begin
         re = ref_i && !rp;
         fe = fb_i && !fp;
         rp = ref_i; fp = fb_i;
         if (pv) begin
            if (pg) begin
               if (run < RUN) run++;
               if (run >= RUN) lk = 1;
            end else begin
               run = 0; lk = 0;
            end
         end
         dv = 0; dg = 0;
         if (re) nref++;
         if (waiting) begin
            if (cyc - wst >= WIN) begin dv = 1; dg = 0; waiting = 0; end
            else if (fe) begin dv = 1; dg = 1; waiting = 0; end
         end else if (re && (nref % DECIM == 0)) begin
            if (fe || (cyc - last_fb < WIN)) begin dv = 1; dg = 1; end
            else begin waiting = 1; wst = cyc; end
         end
         if (re) gap = 0;
         else if (gap == TMO - 1) begin gap = 0; dv = 1; dg = 0; end
         else gap++;
         if (fe) last_fb = cyc;
         pv = dv; pg = dg;
      end
      cyc++;
   end

   // compare against the model every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (lock_o !== (sel && lk)) begin
            errors++;
            $display("FAIL %s model compare t=%0t actual=%0b expected=%0b",
                     cur_req, $time, lock_o, sel && lk);
         end
      end
   end

   task automatic chk(input string req, input logic exp);
      @(negedge clk);
      checks++;
      if (lock_o !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, lock_o, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #0.1;
      checks++;
      if (lock_o !== 1'b0) begin
         errors++;
         $display("FAIL R7 reset actual=%0b expected=0", lock_o);
      end
      wait_clk(4);
      rst_n = 1'b1; sel = 1'b1;
      chk("R7", 1'b0);
      ref_en = 1; fb_en = 1; off = 0; cur_req = "R1";
      // three samples taken (edges 64,128,192), fourth not yet
      wait_clk(3600);
      chk("R1", 1'b0);
      cur_req = "R3";
      wait_clk(1000);
      chk("R3", 1'b1);
      cur_req = "R6";
      sel = 1'b0;
      wait_clk(2000);
      chk("R6", 1'b0);
      sel = 1'b1;
      chk("R6", 1'b1);
      cur_req = "R2";
      off = 1;
      wait_clk(3000);
      chk("R2", 1'b1);
      off = -1;
      wait_clk(3000);
      chk("R2", 1'b1);
      cur_req = "R4";
      off = 2;
      wait_clk(1100);
      chk("R4", 1'b0);
      off = 0;
      wait_clk(1100);
      chk("R4", 1'b0);
      wait_clk(4200);
      chk("R3", 1'b1);
      cur_req = "R2";
      off = -2;
      wait_clk(1100);
      chk("R2", 1'b0);
      off = 0;
      wait_clk(5300);
      chk("R3", 1'b1);
      cur_req = "R5";
      fb_en = 0;
      wait_clk(1100);
      chk("R5", 1'b0);
      fb_en = 1;
      wait_clk(5300);
      chk("R5", 1'b1);
      ref_en = 0;
      wait_clk(600);
      chk("R5", 1'b0);
      ref_en = 1;
      cur_req = "R8";
      wait_clk(5300);
      chk("R8", 1'b1);
      cur_req = "R7";
      rst_n = 1'b0;
      chk("R7", 1'b0);
      wait_clk(2);
      rst_n = 1'b1;
      wait_clk(200);
      chk("R7", 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule